// File: doc/BRIEF.md
# Hash Tree Memory Integrity Checker

This block confirms that a data block fetched from untrusted external memory is the same value that was last written back to it. The data blocks form the leaves of a binary tree of hashes. Every tree node except the root lives in external memory, next to the data. The root is kept in an on-chip register, and it is the only value the block trusts. The cache sends a request to the checker only when it misses (a fetch) or evicts a line (a write-back). Cache hits never reach the block, so they cost no hashing at all.

On a fetch, the checker reads the data block and hands it to the consumer straight away, before it has been verified. It then climbs from the leaf to the root, reading one sibling hash per level, and compares its result with the on-chip root. A mismatch sets a sticky tamper error that only reset clears. A modified block (spoofing), a block moved to another address (splicing) and an older consistent copy (replay) all change the computed root, so each of them is detected. On a write-back, the checker stores the data, rewrites every node on the path, and replaces the root only once the whole path is done. Work that uses the processor secret asks for a grant, and the grant is given only when no check is outstanding.

The request and forward interfaces use valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole of a walk and stays low for good once a tamper error is set. Forwarded data transfers on an edge where `fwd_valid` and `fwd_ready` are both high. While `fwd_ready` is low, `fwd_valid` and `fwd_data` hold their values, and the request does not finish until the forwarded word has been taken. The memory port has a fixed latency: a read issued with `mem_valid` in one cycle returns on `mem_rdata` in the next cycle, and a write takes effect at that same edge.

Top module: `hash_tree_guard`

## Requirements
- R1: After reset, `busy`, `tamper_err`, `fwd_valid`, `mem_valid` and `sec_grant` are 0, and `req_ready` is 1.
- R2: The hash is mix(a,b) = (rotate-left(a, 7) XOR b) + 0x9E3779B9 on 32 bits. Nodes are numbered from 1 (root) to 15, and the children of node p are 2p and 2p+1. Leaf 8+i holds mix(data_i, i). A write-back of data d to block i writes d to data address i. It then writes every node from leaf 8+i up to node 2, and each parent p on that path takes the value mix(node 2p, node 2p+1), with the sibling hashes read back from memory. Node 1 is never written to memory.
- R3: A fetch presents the data word read from memory on `fwd_valid`/`fwd_data` while `busy` is still high. The word stays valid and stable until `fwd_ready` is sampled high.
- R4: When memory holds the data and nodes produced by the preceding write-backs, a fetch returns the last data written to that block and does not set `tamper_err`.
- R5: A fetch of a data block whose value was altered in memory sets `tamper_err`.
- R6: A fetch of a block whose content was swapped with another block's content sets `tamper_err`.
- R7: A fetch of a block after an older data value and its older path nodes have been restored in memory sets `tamper_err`.
- R8: A fetch sets `tamper_err` when a sibling node on its own path was altered. It does not set it when the altered node lies off its path.
- R9: Once set, `tamper_err` stays high and `req_ready` stays low until reset.
- R10: `sec_grant` is high exactly when `sec_req` is high and no fetch or write-back is in progress.
- R11: `req_ready` is low and `busy` is high from the edge after a request is accepted until that request completes, and `mem_valid` is never high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cache request valid |
| req_ready | output | 1 | Checker can accept a request |
| req_write | input | 1 | 1 = write-back, 0 = fetch |
| req_addr | input | 3 | Data block index |
| req_wdata | input | 32 | Write-back data |
| fwd_valid | output | 1 | Speculative fetched word valid |
| fwd_ready | input | 1 | Consumer takes the forwarded word |
| fwd_data | output | 32 | Fetched (not yet verified) word |
| mem_valid | output | 1 | Memory access this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_node | output | 1 | 1 = tree node space, 0 = data space |
| mem_addr | output | 4 | Node number or data block index |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| busy | output | 1 | A walk is in progress |
| tamper_err | output | 1 | Sticky integrity failure |
| sec_req | input | 1 | Request to run a secret-dependent operation |
| sec_grant | output | 1 | Secret-dependent operation may proceed |

## Verification
The assertions check, on every cycle, the properties that hold at all times: the forwarded word stays stable under back-pressure, the error is sticky and blocks new requests, the grant appears only when the block is idle, the memory port is silent when the block is idle, and the root node is never written out. Detection is different. It can only be shown by the bench, which tampers with the memory model in specific ways and then fetches: spoofed, spliced and replayed blocks, a corrupted sibling on the fetched path, and a corrupted node off that path that must not be flagged. The bench also shows the node values left by each write-back, and it shows that a fetch returns the right data under random traffic with no tampering.

// File: rtl/ht_pkg.sv
package ht_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DWR,
    ST_DRD,
    ST_DCAP,
    ST_NWR,
    ST_SRD,
    ST_SCAP,
    ST_FIN
  } walk_st_e;
endpackage

// File: rtl/ht_mix.sv
module ht_mix #(
  parameter int W = 32,
  parameter int ROT = 7,
  parameter logic [W-1:0] HKEY = 'h9E3779B9
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] h
);
  logic [W-1:0] rot;
  assign rot = (a << ROT) | (a >> (W - ROT));
  assign h   = (rot ^ b) + HKEY;
endmodule

// File: rtl/ht_root_keeper.sv
module ht_root_keeper #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic         check,
  input  logic [W-1:0] path_hash,
  output logic         tamper
);
  logic [W-1:0] root_q;
  logic         err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (commit) root_q <= path_hash;
      if (check && (path_hash != root_q)) err_q <= 1'b1;
    end
  end

  assign tamper = err_q;

  // R9: a raised integrity error never drops without reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tamper |=> tamper);
endmodule

// File: rtl/ht_path_walker.sv
module ht_path_walker import ht_pkg::*; #(
  parameter int W = 32,
  parameter int LEAVES = 8,
  parameter int ROT = 7,
  parameter logic [W-1:0] HKEY = 'h9E3779B9,
  localparam int AW = $clog2(LEAVES),
  localparam int NW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic          fwd_valid,
  input  logic          fwd_ready,
  output logic [W-1:0]  fwd_data,
  output logic          mem_valid,
  output logic          mem_write,
  output logic          mem_node,
  output logic [NW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          fin_commit,
  output logic          fin_check,
  output logic [W-1:0]  path_hash
);
  localparam logic [NW-1:0] LEAF_BASE = NW'(LEAVES);
  localparam logic [NW-1:0] ROOT_IDX  = NW'(1);

  walk_st_e       st;
  logic           wr_q;
  logic [AW-1:0]  addr_q;
  logic [W-1:0]   wdata_q;
  logic [NW-1:0]  node_q;
  logic [W-1:0]   cur_q;
  logic           fwd_valid_q;
  logic [W-1:0]   fwd_data_q;
  logic [W-1:0]   mix_a, mix_b, mix_h;
  logic [NW-1:0]  parent;

  assign parent = node_q >> 1;

  always_comb begin
    case (st)
      ST_IDLE: begin mix_a = req_wdata; mix_b = W'(req_addr); end
      ST_DCAP: begin mix_a = mem_rdata; mix_b = W'(addr_q);   end
      default: begin
        if (node_q[0]) begin mix_a = mem_rdata; mix_b = cur_q;     end
        else           begin mix_a = cur_q;     mix_b = mem_rdata; end
      end
    endcase
  end

  ht_mix #(.W(W), .ROT(ROT), .HKEY(HKEY)) i_mix (
    .a(mix_a), .b(mix_b), .h(mix_h)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      node_q      <= '0;
      cur_q       <= '0;
      fwd_valid_q <= 1'b0;
      fwd_data_q  <= '0;
    end else begin
      if (fwd_valid_q && fwd_ready) fwd_valid_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid && req_ready) begin
          wr_q    <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          node_q  <= LEAF_BASE + NW'(req_addr);
          if (req_write) begin
            cur_q <= mix_h;
            st    <= ST_DWR;
          end else begin
            st    <= ST_DRD;
          end
        end
        ST_DWR:  st <= ST_NWR;
        ST_DRD:  st <= ST_DCAP;
        ST_DCAP: begin
          cur_q       <= mix_h;
          fwd_valid_q <= 1'b1;
          fwd_data_q  <= mem_rdata;
          st          <= ST_SRD;
        end
        ST_NWR:  st <= ST_SRD;
        ST_SRD:  st <= ST_SCAP;
        ST_SCAP: begin
          cur_q  <= mix_h;
          node_q <= parent;
          if (parent == ROOT_IDX) st <= ST_FIN;
          else if (wr_q)          st <= ST_NWR;
          else                    st <= ST_SRD;
        end
        ST_FIN:  if (!fwd_valid_q) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = (st == ST_DWR) || (st == ST_DRD) || (st == ST_NWR) || (st == ST_SRD);
    mem_write = (st == ST_DWR) || (st == ST_NWR);
    mem_node  = (st == ST_NWR) || (st == ST_SRD);
    case (st)
      ST_NWR:  mem_addr = node_q;
      ST_SRD:  mem_addr = node_q ^ NW'(1);
      default: mem_addr = NW'(addr_q);
    endcase
    mem_wdata = (st == ST_DWR) ? wdata_q : cur_q;
  end

  assign req_ready  = (st == ST_IDLE) && !halt;
  assign busy       = (st != ST_IDLE);
  assign fwd_valid  = fwd_valid_q;
  assign fwd_data   = fwd_data_q;
  assign fin_commit = (st == ST_FIN) && !fwd_valid_q && wr_q;
  assign fin_check  = (st == ST_FIN) && !fwd_valid_q && !wr_q;
  assign path_hash  = cur_q;

  // R11: an accepted request makes the block busy on the next edge
  a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));
  // R11: no memory traffic when idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);
  // R3: forwarded word is held under back-pressure
  a_r3_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_data)));
  // R2: the trusted root never leaves the chip
  a_r2_root_on_chip: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_node) |-> (mem_addr > ROOT_IDX));
endmodule

// File: rtl/hash_tree_guard.sv
module hash_tree_guard #(
  parameter int W = 32,
  parameter int LEAVES = 8,
  parameter int ROT = 7,
  parameter logic [W-1:0] HKEY = 'h9E3779B9,
  localparam int AW = $clog2(LEAVES),
  localparam int NW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic          fwd_valid,
  input  logic          fwd_ready,
  output logic [W-1:0]  fwd_data,
  output logic          mem_valid,
  output logic          mem_write,
  output logic          mem_node,
  output logic [NW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          tamper_err,
  input  logic          sec_req,
  output logic          sec_grant
);
  logic         fin_commit, fin_check;
  logic [W-1:0] path_hash;

  ht_path_walker #(.W(W), .LEAVES(LEAVES), .ROT(ROT), .HKEY(HKEY)) i_walker (
    .clk(clk), .rst_n(rst_n), .halt(tamper_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_data(fwd_data),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_node(mem_node),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .fin_commit(fin_commit), .fin_check(fin_check),
    .path_hash(path_hash)
  );

  ht_root_keeper #(.W(W)) i_keeper (
    .clk(clk), .rst_n(rst_n), .commit(fin_commit), .check(fin_check),
    .path_hash(path_hash), .tamper(tamper_err)
  );

  assign sec_grant = sec_req && !busy;

  // R10: secret-dependent work never overlaps an outstanding check
  a_r10_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sec_grant |-> !busy);
  // R9: after an integrity failure no request is accepted
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_err |-> !req_ready);
endmodule

// File: tb/test_hash_tree_guard.sv
module test_hash_tree_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, fwd_valid, busy, tamper_err, sec_grant;
  logic        fwd_ready = 1'b0, sec_req = 1'b0;
  logic [31:0] fwd_data, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_valid, mem_write, mem_node;
  logic [3:0]  mem_addr;

  logic [31:0] data_mem [0:7];
  logic [31:0] node_mem [0:15];
  logic [31:0] gdata [0:7];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_tree_guard i_hash_tree_guard (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_data(fwd_data),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_node(mem_node),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .tamper_err(tamper_err), .sec_req(sec_req), .sec_grant(sec_grant)
  );

  // external memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_valid) begin
      if (mem_write) begin
        if (mem_node) node_mem[mem_addr] <= mem_wdata;
        else          data_mem[mem_addr[2:0]] <= mem_wdata;
      end else begin
        mem_rdata <= mem_node ? node_mem[mem_addr] : data_mem[mem_addr[2:0]];
      end
    end
  end

  function automatic logic [31:0] bmix(input logic [31:0] a, input logic [31:0] b);
    return ({a[24:0], a[31:25]} ^ b) + 32'h9E3779B9;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic issue(input bit w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wb(input logic [2:0] a, input logic [31:0] d);
    issue(1'b1, a, d);
    wait_idle();
    gdata[a] = d;
  endtask

  task automatic fetch(input logic [2:0] a, output logic [31:0] got,
                       output bit spec, output bit hold_ok, output bit err);
    int dly;
    issue(1'b0, a, '0);
    while (!fwd_valid) @(negedge clk);
    got = fwd_data;
    spec = busy;
    hold_ok = 1'b1;
    dly = $urandom_range(0, 3);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      if (!fwd_valid || fwd_data != got) hold_ok = 1'b0;
    end
    fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0;
    wait_idle();
    err = tamper_err;
  endtask

  task automatic init_all();
    for (int i = 0; i < 8; i++) wb(3'(i), $urandom);
  endtask

  task automatic check_tree(input string req);
    logic [31:0] exp [1:15];
    bit ok = 1'b1;
    logic [31:0] bad_a = '0, bad_e = '0;
    for (int i = 8; i < 16; i++) exp[i] = bmix(gdata[i-8], 32'(i-8));
    for (int i = 7; i >= 1; i--) exp[i] = bmix(exp[2*i], exp[2*i+1]);
    for (int i = 2; i < 16; i++)
      if (node_mem[i] !== exp[i] && ok) begin ok = 1'b0; bad_a = node_mem[i]; bad_e = exp[i]; end
    for (int i = 0; i < 8; i++)
      if (data_mem[i] !== gdata[i] && ok) begin ok = 1'b0; bad_a = data_mem[i]; bad_e = gdata[i]; end
    chk(ok, req, bad_a, bad_e);
    chk(node_mem[1] === 32'hDEADBEEF, "R2 root not stored", node_mem[1], 32'hDEADBEEF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual=hung expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] got, sv_d, sv_l, sv_p, sv_g, tmp;
    bit spec, hold_ok, err, quiet;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) node_mem[i] = '0;
    for (int i = 0; i < 8; i++) begin data_mem[i] = '0; gdata[i] = '0; end
    node_mem[1] = 32'hDEADBEEF;

    do_reset();
    @(negedge clk);
    chk(!busy && !tamper_err && !fwd_valid && !mem_valid && !sec_grant, "R1 idle outputs",
        {27'd0, busy, tamper_err, fwd_valid, mem_valid, sec_grant}, 32'd0);
    chk(req_ready, "R1 req_ready", {31'd0, req_ready}, 32'd1);

    init_all();
    check_tree("R2 tree after init");

    // random traffic with intact memory
    for (int n = 0; n < 40; n++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) begin
        wb(a, $urandom);
        if (n % 8 == 0) check_tree("R2 tree after write-back");
      end else begin
        fetch(a, got, spec, hold_ok, err);
        chk(got == gdata[a], "R4 fetched data", got, gdata[a]);
        chk(spec, "R3 forwarded before verify", {31'd0, spec}, 32'd1);
        chk(hold_ok, "R3 forward held", {31'd0, hold_ok}, 32'd1);
        chk(!err, "R4 no false error", {31'd0, err}, 32'd0);
      end
    end
    check_tree("R2 tree after traffic");

    // R10 and R11 during a walk
    sec_req = 1'b1;
    issue(1'b1, 3'd4, 32'h1234_5678);
    chk(busy && !req_ready, "R11 busy blocks requests", {30'd0, busy, req_ready}, 32'd2);
    chk(!sec_grant, "R10 grant withheld while busy", {31'd0, sec_grant}, 32'd0);
    wait_idle();
    gdata[4] = 32'h1234_5678;
    chk(sec_grant, "R10 grant when idle", {31'd0, sec_grant}, 32'd1);
    sec_req = 1'b0;
    @(negedge clk);
    chk(!sec_grant, "R10 grant follows request", {31'd0, sec_grant}, 32'd0);
    quiet = 1'b1;
    for (int k = 0; k < 5; k++) begin @(negedge clk); if (mem_valid) quiet = 1'b0; end
    chk(quiet, "R11 memory quiet when idle", {31'd0, quiet}, 32'd1);

    // R8: corrupted node off the path, then on the path
    node_mem[4] = node_mem[4] ^ 32'h1;
    fetch(3'd6, got, spec, hold_ok, err);
    chk(!err, "R8 off-path node ignored", {31'd0, err}, 32'd0);
    chk(got == gdata[6], "R8 off-path data", got, gdata[6]);
    fetch(3'd2, got, spec, hold_ok, err);
    chk(err, "R8 on-path sibling detected", {31'd0, err}, 32'd1);
    node_mem[4] = node_mem[4] ^ 32'h1;
    do_reset(); init_all();

    // R5 spoofing
    data_mem[3] = data_mem[3] ^ 32'h8000_0000;
    fetch(3'd3, got, spec, hold_ok, err);
    chk(got == (gdata[3] ^ 32'h8000_0000), "R3 speculative word forwarded", got, gdata[3] ^ 32'h8000_0000);
    chk(err, "R5 spoof detected", {31'd0, err}, 32'd1);
    quiet = 1'b1;
    for (int k = 0; k < 5; k++) begin @(negedge clk); if (req_ready || !tamper_err) quiet = 1'b0; end
    chk(quiet, "R9 error sticky and blocking", {30'd0, req_ready, tamper_err}, 32'd1);
    do_reset();
    chk(!tamper_err && req_ready, "R9 reset clears error", {30'd0, req_ready, tamper_err}, 32'd2);
    init_all();

    // R6 splicing
    wb(3'd1, 32'hAAAA_0001);
    wb(3'd2, 32'h5555_0002);
    tmp = data_mem[1]; data_mem[1] = data_mem[2]; data_mem[2] = tmp;
    fetch(3'd1, got, spec, hold_ok, err);
    chk(err, "R6 splice detected", {31'd0, err}, 32'd1);
    do_reset(); init_all();

    // R7 replay of an older consistent value and path
    sv_d = data_mem[5]; sv_l = node_mem[13]; sv_p = node_mem[6]; sv_g = node_mem[3];
    wb(3'd5, sv_d ^ 32'h0F0F_0F0F);
    data_mem[5] = sv_d; node_mem[13] = sv_l; node_mem[6] = sv_p; node_mem[3] = sv_g;
    fetch(3'd5, got, spec, hold_ok, err);
    chk(got == sv_d, "R7 stale word forwarded", got, sv_d);
    chk(err, "R7 replay detected", {31'd0, err}, 32'd1);

    finish_run();
  end
endmodule